// File: doc/BRIEF.md
# EDO DRAM Random Access Sequencer

This block runs one random access at a time, read or early write, against an asynchronous EDO DRAM. The DRAM has a shared row/column address bus. A host raises `req` with a write flag, a linear word address and write data. The sequencer then drives the row strobe, column strobe, write enable and output enable low and high in turn. It places the row half of the address on the shared bus, then the column half, and drives or releases the data bus. It finishes with a one-cycle `done` pulse that carries the read data.

Every DRAM minimum time is a picosecond parameter. It is turned into whole clock cycles by rounding up against the clock period parameter, which defaults to 10000 ps. The event schedule inside an access is derived from those cycle counts. This includes the point where the column address replaces the row, the column strobe falling edge, the data sample point, the strobe release and the precharge tail. Because of that schedule, the row strobe minimum width, the precharge time and the access-to-access cycle time are all met without the host tracking any of them.

Top module: `dram_access_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `ras_n`, `cas_n`, `we_n` and `oe_n` are 1, and `dq_oe` and `done` are 0.
- R2: In the first cycle after a request is accepted, `ma` holds `addr[23:12]` (the row). From the second cycle until the next accepted request, `ma` holds `addr[11:0]` (the column), captured at acceptance.
- R3: With default parameters, `ras_n` goes low at the accepting edge and stays low for exactly 5 cycles. `cas_n` goes low 2 cycles after `ras_n` falls and returns high at the same edge as `ras_n`.
- R4: In a read (`wr`=0 at acceptance), `oe_n` is low exactly while `ras_n` is low, `we_n` stays 1 and `dq_oe` stays 0. `rdata` takes the value on `dq_in` at the edge where `ras_n` rises.
- R5: In an early write (`wr`=1 at acceptance), `we_n` is low and `dq_oe` is 1 with `dq_out` equal to the accepted `wdata` from the `ras_n` falling edge to the `ras_n` rising edge, which covers the `cas_n` falling edge. `oe_n` stays 1.
- R6: With `req` held high, the next `ras_n` falling edge comes exactly 9 cycles after the previous one. `ras_n` is then high for 4 cycles between accesses.
- R7: A request raised while an access is in progress is ignored. It changes neither the bus address, the strobes, the direction nor the read data of that access, and starts no new access.
- R8: `done` is high for exactly one cycle, starting in the cycle after `ras_n` rises. `rdata` is valid with it and keeps its value until the next read completes; a write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, taken only when idle |
| wr | input | 1 | 1 = early write, 0 = read |
| addr | input | 24 | Linear word address, row in the upper half |
| wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Registered read data |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |
| oe_n | output | 1 | DRAM output enable, active low |
| ma | output | 12 | Multiplexed DRAM address bus |
| dq_out | output | 8 | Data driven toward the DRAM |
| dq_oe | output | 1 | Enable for the data bus drivers |
| dq_in | input | 8 | Data returned from the DRAM bus |

## Verification
The bench goes after the row-to-column switch. A design that moved the column onto the bus too early would lose the row, and one that moved it too late would let the column strobe latch the row bits. It checks that read data is taken exactly as the row strobe rises. An off-by-one there returns the idle bus value instead of the cell contents. It also holds the request high across accesses and injects a request with a flipped direction mid-access, which catches a sequencer that shortens precharge, restarts early, or lets the new write flag turn a read into a write. A write followed by a read-back of the same word, plus reads of the lowest and highest addresses, exposes swapped or truncated row and column halves.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  // Round a picosecond interval up to whole clock cycles.
  function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Phase of one access: strobe open, precharge tail, or free.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OPEN = 2'd1,
    PH_PRE  = 2'd2
  } seq_phase_t;

endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer
  import dram_seq_pkg::*;
#(
  parameter int COL_AT  = 1,
  parameter int CAS_AT  = 2,
  parameter int END_AT  = 5,
  parameter int LAST_AT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic ev_col,
  output logic ev_cas,
  output logic ev_end
);
  localparam int CW = $clog2(LAST_AT + 2);

  seq_phase_t      phase;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   nxt;
  logic            ev_last;

  // nxt is the edge index (counted from the row strobe edge) about to occur
  assign nxt     = cnt + 1'b1;
  assign busy    = (phase != PH_IDLE);
  assign ev_col  = busy && (nxt == CW'(COL_AT));
  assign ev_cas  = busy && (nxt == CW'(CAS_AT));
  assign ev_end  = busy && (nxt == CW'(END_AT));
  assign ev_last = busy && (nxt == CW'(LAST_AT));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        phase <= PH_OPEN;
        cnt   <= '0;
      end
    end else begin
      cnt <= nxt;
      if (ev_end)  phase <= PH_PRE;
      if (ev_last) phase <= PH_IDLE;
    end
  end

  // R3: the column strobe event only happens while the row is open
  a_r3_cas_in_open: assert property (@(posedge clk) disable iff (rst)
    ev_cas |-> (phase == PH_OPEN));

  // R7: a start can only be seen from the idle phase
  a_r7_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> (phase != PH_IDLE) || ($past(ev_last)));

endmodule

// File: rtl/dram_seq_addr.sv
module dram_seq_addr #(
  parameter int ADDR_W = 24,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 12,
  parameter int MA_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ev_col,
  input  logic [ADDR_W-1:0] addr,
  output logic [MA_W-1:0]   ma
);
  logic [MA_W-1:0] row_ext;
  logic [MA_W-1:0] col_ext;
  logic [MA_W-1:0] col_q;

  assign row_ext = MA_W'(addr[ADDR_W-1 -: ROW_W]);
  assign col_ext = MA_W'(addr[COL_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ma    <= '0;
      col_q <= '0;
    end else begin
      if (start) begin
        ma    <= row_ext;
        col_q <= col_ext;
      end else if (ev_col) begin
        ma <= col_q;
      end
    end
  end

  // R2: once the column is on the bus it stays until the next start
  a_r2_col_held: assert property (@(posedge clk) disable iff (rst)
    ($past(ev_col) && !start) |=> $stable(ma) || $past(start));

endmodule

// File: rtl/dram_seq_strobe.sv
module dram_seq_strobe
  import dram_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_RAS = 5,
  parameter int MIN_RP  = 3,
  parameter int MIN_RC  = 9,
  parameter int MIN_RCD = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ev_cas,
  input  logic              ev_end,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  logic wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_n  <= 1'b1;
      cas_n  <= 1'b1;
      we_n   <= 1'b1;
      oe_n   <= 1'b1;
      dq_oe  <= 1'b0;
      dq_out <= '0;
      done   <= 1'b0;
      rdata  <= '0;
      wr_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        wr_q  <= wr;
        ras_n <= 1'b0;
        if (wr) begin
          we_n   <= 1'b0;
          dq_oe  <= 1'b1;
          dq_out <= wdata;
        end else begin
          oe_n <= 1'b0;
        end
      end
      if (ev_cas) cas_n <= 1'b0;
      if (ev_end) begin
        ras_n <= 1'b1;
        cas_n <= 1'b1;
        we_n  <= 1'b1;
        oe_n  <= 1'b1;
        dq_oe <= 1'b0;
        done  <= 1'b1;
        if (!wr_q) rdata <= dq_in;
      end
    end
  end

  // Window counters for the timing checks below (saturating)
  localparam int SW = $clog2(imax(MIN_RC, imax(MIN_RAS, 2)) + 2);
  logic [SW-1:0] low_len, high_len, gap_len;
  logic          ras_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_len  <= '0;
      high_len <= '1;
      gap_len  <= '1;
      ras_d    <= 1'b1;
    end else begin
      ras_d <= ras_n;
      if (ras_n) low_len <= '0;
      else if (low_len != '1) low_len <= low_len + 1'b1;
      if (!ras_n) high_len <= '0;
      else if (high_len != '1) high_len <= high_len + 1'b1;
      if (ras_d && !ras_n) gap_len <= SW'(1);
      else if (gap_len != '1) gap_len <= gap_len + 1'b1;
    end
  end

  a_r3_ras_min_width: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (low_len >= SW'(MIN_RAS)));

  a_r3_rcd_min: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> (low_len >= SW'(MIN_RCD)));

  a_r3_cas_inside_ras: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);

  a_r6_precharge_min: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (high_len >= SW'(MIN_RP)));

  a_r6_cycle_min: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (gap_len >= SW'(MIN_RC)));

  a_r4_no_bus_fight: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !dq_oe);

  a_r5_write_drives: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (dq_oe && oe_n && !ras_n));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_after_ras: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(ras_n));

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 12,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 10000,
  parameter int T_RAS_PS  = 50000,
  parameter int T_RP_PS   = 30000,
  parameter int T_RC_PS   = 84000,
  parameter int T_RCD_PS  = 12000,
  parameter int T_RAH_PS  = 8000,
  parameter int T_CAH_PS  = 8000,
  parameter int T_CAS_PS  = 8000,
  parameter int T_CRP_PS  = 5000,
  parameter int T_RAC_PS  = 50000,
  parameter int T_CAC_PS  = 13000,
  parameter int T_AA_PS   = 25000,
  parameter int T_WCH_PS  = 8000,
  parameter int T_DH_PS   = 7000,
  parameter int MA_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [MA_W-1:0]   ma,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);
  // Minimum times in whole cycles, rounded up
  localparam int C_RAS = ps_to_cyc(T_RAS_PS, CLK_PS);
  localparam int C_RP  = ps_to_cyc(T_RP_PS,  CLK_PS);
  localparam int C_RC  = ps_to_cyc(T_RC_PS,  CLK_PS);
  localparam int C_RCD = ps_to_cyc(T_RCD_PS, CLK_PS);
  localparam int C_RAH = ps_to_cyc(T_RAH_PS, CLK_PS);
  localparam int C_CAH = ps_to_cyc(T_CAH_PS, CLK_PS);
  localparam int C_CAS = ps_to_cyc(T_CAS_PS, CLK_PS);
  localparam int C_CRP = ps_to_cyc(T_CRP_PS, CLK_PS);
  localparam int C_RAC = ps_to_cyc(T_RAC_PS, CLK_PS);
  localparam int C_CAC = ps_to_cyc(T_CAC_PS, CLK_PS);
  localparam int C_AA  = ps_to_cyc(T_AA_PS,  CLK_PS);
  localparam int C_WCH = ps_to_cyc(T_WCH_PS, CLK_PS);
  localparam int C_DH  = ps_to_cyc(T_DH_PS,  CLK_PS);

  // Event schedule, as edge indices after the row strobe edge
  localparam int COL_AT  = imax(1, C_RAH);
  localparam int CAS_AT  = imax(C_RCD, COL_AT);
  localparam int SMP_AT  = imax(C_RAC, imax(COL_AT + C_AA, CAS_AT + C_CAC));
  localparam int HOLD_AT = CAS_AT + imax(1, imax(imax(C_CAS, C_CAH), imax(C_WCH, C_DH)));
  localparam int END_AT  = imax(imax(C_RAS, SMP_AT), HOLD_AT);
  localparam int PRE_LEN = imax(1, imax(imax(C_RP, C_CRP), C_RC - END_AT));
  localparam int LAST_AT = END_AT + PRE_LEN - 1;

  logic busy, start, ev_col, ev_cas, ev_end;

  assign start = req && !busy;

  dram_seq_timer #(
    .COL_AT (COL_AT),
    .CAS_AT (CAS_AT),
    .END_AT (END_AT),
    .LAST_AT(LAST_AT)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .ev_col(ev_col),
    .ev_cas(ev_cas),
    .ev_end(ev_end)
  );

  dram_seq_addr #(
    .ADDR_W(ADDR_W),
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .MA_W  (MA_W)
  ) u_addr (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ev_col(ev_col),
    .addr  (addr),
    .ma    (ma)
  );

  dram_seq_strobe #(
    .DATA_W (DATA_W),
    .MIN_RAS(C_RAS),
    .MIN_RP (C_RP),
    .MIN_RC (C_RC),
    .MIN_RCD(C_RCD)
  ) u_strobe (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .wr    (wr),
    .wdata (wdata),
    .ev_cas(ev_cas),
    .ev_end(ev_end),
    .dq_in (dq_in),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .oe_n  (oe_n),
    .dq_out(dq_out),
    .dq_oe (dq_oe),
    .done  (done),
    .rdata (rdata)
  );

  // R2: the column strobe never falls while the row is still on the bus
  a_r2_col_before_cas: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> !$fell(ras_n));

endmodule

// File: tb/dram_access_seq_bench.sv
module dram_access_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        wr  = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        done, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [7:0]  rdata, dq_out, dq_in;
  logic [11:0] ma;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dram_access_seq u_dram_access_seq (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .done(done), .rdata(rdata), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .ma(ma), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  // Behavioural DRAM: latches row and column on strobe falls
  logic [7:0]  mem [int];
  logic [11:0] m_row = '0, m_col = '0;
  logic [7:0]  m_val = '0;
  logic        m_ras_p = 1'b1, m_cas_p = 1'b1;

  function automatic logic [7:0] pattern(input logic [23:0] k);
    return k[7:0] ^ k[15:8] ^ k[23:16] ^ 8'h3C;
  endfunction

  always @(negedge clk) begin
    if (!ras_n && m_ras_p) m_row = ma;
    if (!cas_n && m_cas_p && !ras_n) begin
      m_col = ma;
      if (!we_n && dq_oe) mem[int'({m_row, m_col})] = dq_out;
      m_val = mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})]
                                                : pattern({m_row, m_col});
    end
    m_ras_p = ras_n;
    m_cas_p = cas_n;
  end

  assign dq_in = (!ras_n && !cas_n && !oe_n) ? m_val : 8'h00;

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Trace, index k = sample after the k-th edge counted from the accepting edge
  localparam int TN = 24;
  logic        tr_ras [TN], tr_cas [TN], tr_we [TN], tr_oe [TN], tr_dqoe [TN], tr_done [TN];
  logic [11:0] tr_ma  [TN];
  logic [7:0]  tr_dqo [TN], tr_rd [TN];

  task automatic launch(input logic w, input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(posedge clk);
  endtask

  task automatic capture(input int n, input int drop_k, input int inj_k,
                         input logic [23:0] inj_a, input logic [23:0] next_a);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tr_ras[k] = ras_n; tr_cas[k] = cas_n; tr_we[k] = we_n; tr_oe[k] = oe_n;
      tr_dqoe[k] = dq_oe; tr_done[k] = done; tr_ma[k] = ma;
      tr_dqo[k] = dq_out; tr_rd[k] = rdata;
      if (k == 0) addr = next_a;
      if (k == drop_k) req = 1'b0;
      if (k == inj_k) begin req = 1'b1; addr = inj_a; wr = ~wr; end
      if (k == inj_k + 1) req = 1'b0;
    end
  endtask

  task automatic check_access(input logic w, input logic [23:0] a, input logic [7:0] d,
                              input logic [7:0] exp_rd);
    for (int k = 0; k < 9; k++) begin
      chk("R3", $sformatf("ras_n k=%0d", k), 32'(tr_ras[k]), 32'(k >= 5));
      chk("R3", $sformatf("cas_n k=%0d", k), 32'(tr_cas[k]), 32'(!(k >= 2 && k < 5)));
      chk("R2", $sformatf("ma k=%0d", k), 32'(tr_ma[k]), (k == 0) ? 32'(a[23:12]) : 32'(a[11:0]));
      chk("R8", $sformatf("done k=%0d", k), 32'(tr_done[k]), 32'(k == 5));
      if (w) begin
        chk("R5", $sformatf("we_n k=%0d", k), 32'(tr_we[k]), 32'(k >= 5));
        chk("R5", $sformatf("oe_n k=%0d", k), 32'(tr_oe[k]), 32'd1);
        chk("R5", $sformatf("dq_oe k=%0d", k), 32'(tr_dqoe[k]), 32'(k < 5));
        if (k < 5) chk("R5", $sformatf("dq_out k=%0d", k), 32'(tr_dqo[k]), 32'(d));
      end else begin
        chk("R4", $sformatf("oe_n k=%0d", k), 32'(tr_oe[k]), 32'(k >= 5));
        chk("R4", $sformatf("we_n k=%0d", k), 32'(tr_we[k]), 32'd1);
        chk("R4", $sformatf("dq_oe k=%0d", k), 32'(tr_dqoe[k]), 32'd0);
      end
    end
    chk(w ? "R8" : "R4", "rdata with done", 32'(tr_rd[5]), 32'(exp_rd));
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "ras_n in reset", 32'(ras_n), 32'd1);
    chk("R1", "cas_n in reset", 32'(cas_n), 32'd1);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1", "we_n after reset", 32'(we_n), 32'd1);
    chk("R1", "oe_n after reset", 32'(oe_n), 32'd1);
    chk("R1", "dq_oe after reset", 32'(dq_oe), 32'd0);
    chk("R1", "done after reset", 32'(done), 32'd0);
  endtask

  task automatic t_read(input logic [23:0] a);
    launch(1'b0, a, 8'h00);
    capture(10, 0, -5, '0, a);
    check_access(1'b0, a, 8'h00, pattern(a));
    settle();
  endtask

  task automatic t_write_readback();
    logic [7:0] prev;
    prev = rdata;
    launch(1'b1, 24'h5A5A5A, 8'hC7);
    capture(10, 0, -5, '0, 24'h5A5A5A);
    check_access(1'b1, 24'h5A5A5A, 8'hC7, prev);
    chk("R8", "rdata after write", 32'(tr_rd[9]), 32'(prev));
    settle();
    launch(1'b0, 24'h5A5A5A, 8'h00);
    capture(10, 0, -5, '0, 24'h5A5A5A);
    check_access(1'b0, 24'h5A5A5A, 8'h00, 8'hC7);
    settle();
  endtask

  task automatic t_back_to_back();
    logic [23:0] a, b;
    int first_fall;
    a = 24'h123456; b = 24'hFEDCBA;
    launch(1'b0, a, 8'h00);
    capture(20, 9, -5, '0, b);
    first_fall = -1;
    for (int k = 1; k < 20; k++)
      if (first_fall < 0 && tr_ras[k-1] && !tr_ras[k]) first_fall = k;
    chk("R6", "next row strobe fall index", 32'(first_fall), 32'd9);
    for (int k = 5; k < 9; k++)
      chk("R6", $sformatf("precharge high k=%0d", k), 32'(tr_ras[k]), 32'd1);
    chk("R6", "second row address", 32'(tr_ma[9]), 32'(b[23:12]));
    chk("R8", "second done", 32'(tr_done[14]), 32'd1);
    chk("R8", "second rdata", 32'(tr_rd[14]), 32'(pattern(b)));
    settle();
  endtask

  task automatic t_busy_ignore();
    logic [23:0] c;
    c = 24'h0F0E0D;
    launch(1'b0, c, 8'h00);
    capture(16, 0, 2, 24'hAAAAAA, c);
    check_access(1'b0, c, 8'h00, pattern(c));
    for (int k = 5; k < 16; k++)
      chk("R7", $sformatf("no new access k=%0d", k), 32'(tr_ras[k]), 32'd1);
    chk("R7", "column kept at k=4", 32'(tr_ma[4]), 32'(c[11:0]));
    chk("R7", "column kept at k=15", 32'(tr_ma[15]), 32'(c[11:0]));
    wr = 1'b0;
    settle();
  endtask

  bit finished = 0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_read(24'hABC123);
    t_write_readback();
    t_read(24'h000000);
    t_read(24'hFFFFFF);
    t_back_to_back();
    t_busy_ignore();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule